// File: doc/BRIEF.md
# I2C Burst Master with Register Window

This block is an I2C master that a host drives through a small byte-wide register window. Its typical use is fetching monitor identification data from a display-data-channel slave. A single transaction moves between 1 and 16 bytes through a local 16-entry buffer. The host loads the target address and the direction, the byte count and, for writes, the buffer. It then starts the burst with one control write and polls the status register until the busy flag drops.

After a burst, the master holds the bus with SCL low. The host ends the transaction with a second control write that issues STOP. It can also begin another burst straight away, which produces a repeated START. A typical read sequence is a one-byte write that sets the slave's internal offset, followed by a repeated-START read.

The SCL and SDA pins are open-drain. Each pin is modelled as a pull-low enable output plus a sampled input. The bit rate comes from a quarter-period divider of the system clock.

Top module: `i2c_burst_master`

## Requirements
- R1: A write to the byte-count register (offset 0x00) keeps only its low 4 bits. A burst moves count+1 bytes, so between 1 and 16.
- R2: In the slave-address register (offset 0x03), bits 7:1 hold the 7-bit target and bit 0 gives the direction (1 = read from the slave, 0 = write to it). The same 8 bits form the address byte on the wire.
- R3: A write to the control register (offset 0x01) with bit 0 clear has no effect on the bus or on the status.
- R4: A control write with bits 0 and 2 set starts a burst: START (or a repeated START if the bus is held), the address byte, then the data bytes. Status bit 0 (busy) is high from the start until the burst finishes or aborts.
- R5: A control write with bit 0 set and bit 2 clear clears status bit 2. If the bus is held, it also issues STOP and afterwards releases both lines.
- R6: A missing acknowledge on the address byte or on any written data byte sets status bit 2, clears busy and skips the remaining bytes.
- R7: A burst in which every byte transfers without error loads the status register (offset 0x02) with 0x08.
- R8: A write of any value to the reset register (offset 0x04) clears status bit 2 and leaves the other status bits unchanged.
- R9: The buffer occupies offsets 0x05 to 0x14. Entry 0 is sent first and then upward, and received bytes land in the same order.
- R10: The count, status, slave-address and buffer registers read back their current value one clock after the address is presented. After reset all of them are zero.
- R11: The control and reset offsets, and offsets 0x15 and above, read as zero. Writes to offsets 0x15 and above change nothing.
- R12: In a read burst the master acknowledges every received byte except the last, which it leaves unacknowledged.
- R13: SDA changes only while SCL is held low, except while a START or STOP is being formed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | ADDR_W | Register offset |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Registered read data for the offset presented in the previous cycle |
| scl_in | input | 1 | Sampled level of the SCL line |
| sda_in | input | 1 | Sampled level of the SDA line |
| scl_oe | output | 1 | Pull SCL low when high |
| sda_oe | output | 1 | Pull SDA low when high |

## Verification
A behavioural slave at address 0x50 sits on a wired-AND bus. Stimulus includes a three-byte write burst (offset byte plus two data bytes) and a four-byte repeated-START read. These show that buffer order and the slave's stored contents match, and that busy, completion and release behave correctly. A full sixteen-byte read exercises the count boundary. Counting the bytes the slave is asked for shows whether the last byte was left unacknowledged. An address the slave ignores, and a slave that refuses the second data byte, separate an address-phase abort from a mid-burst abort. Comparing the status value around each abort shows that the error bit coexists with the earlier completion code until the reset register or a STOP clears it.

// File: rtl/i2cb_pkg.sv
package i2cb_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_BYTE,
    ST_HOLD,
    ST_STOP
  } eng_st_e;

  localparam int OFS_COUNT = 0;
  localparam int OFS_CTRL  = 1;
  localparam int OFS_STAT  = 2;
  localparam int OFS_SADDR = 3;
  localparam int OFS_CLR   = 4;
  localparam int OFS_DATA  = 5;

  localparam int CTL_EN  = 0;
  localparam int CTL_GO  = 2;
  localparam int STS_BSY = 0;
  localparam int STS_ERR = 2;
  localparam logic [7:0] STS_DONE = 8'h08;
endpackage

// File: rtl/i2cb_tick.sv
module i2cb_tick #(
  parameter int DIV = 250
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else if (cnt == CW'(DIV - 1)) begin
      cnt  <= '0;
      tick <= 1'b1;
    end else begin
      cnt  <= cnt + 1'b1;
      tick <= 1'b0;
    end
  end
endmodule

// File: rtl/i2cb_engine.sv
module i2cb_engine
  import i2cb_pkg::*;
#(
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             go,
  input  logic             halt,
  input  logic [7:0]       addr_byte,
  input  logic [IDX_W-1:0] last_idx,
  input  logic [7:0]       tx_byte,
  input  logic             scl_in,
  input  logic             sda_in,
  output logic             scl_oe,
  output logic             sda_oe,
  output logic [IDX_W-1:0] idx,
  output logic             rx_we,
  output logic [IDX_W-1:0] rx_idx,
  output logic [7:0]       rx_byte,
  output logic             done,
  output logic             err,
  output logic             ready,
  output eng_st_e          state
);
  logic [1:0]       q;
  logic [3:0]       bitn;
  logic             is_addr, rw_q, ack_bit;
  logic [IDX_W-1:0] last_q;
  logic [7:0]       shift, out_byte;
  logic             sends;

  assign sends    = is_addr | ~rw_q;
  assign out_byte = (bitn == 4'd0 && !is_addr && !rw_q) ? tx_byte : shift;
  assign ready    = (state == ST_IDLE) || (state == ST_HOLD);

  always_ff @(posedge clk) begin
    rx_we <= 1'b0;
    done  <= 1'b0;
    err   <= 1'b0;
    if (rst) begin
      state   <= ST_IDLE;
      q       <= '0;
      bitn    <= '0;
      is_addr <= 1'b0;
      rw_q    <= 1'b0;
      ack_bit <= 1'b0;
      last_q  <= '0;
      shift   <= '0;
      idx     <= '0;
      rx_idx  <= '0;
      rx_byte <= '0;
      scl_oe  <= 1'b0;
      sda_oe  <= 1'b0;
    end else begin
      case (state)
        ST_IDLE, ST_HOLD: begin
          q <= '0;
          if (go) begin
            state  <= ST_START;
            rw_q   <= addr_byte[0];
            last_q <= last_idx;
            shift  <= addr_byte;
          end else if (halt && state == ST_HOLD) begin
            state <= ST_STOP;
          end
        end
        ST_START: if (tick) begin
          q <= q + 1'b1;
          case (q)
            2'd0: sda_oe <= 1'b0;
            2'd1: scl_oe <= 1'b0;
            2'd2: sda_oe <= 1'b1;
            default: begin
              scl_oe  <= 1'b1;
              state   <= ST_BYTE;
              bitn    <= '0;
              is_addr <= 1'b1;
              idx     <= '0;
            end
          endcase
        end
        ST_BYTE: if (tick) begin
          case (q)
            2'd0: begin
              q <= 2'd1;
              if (bitn == 4'd8) begin
                sda_oe <= sends ? 1'b0 : (idx != last_q);
              end else begin
                sda_oe <= sends & ~out_byte[7];
                shift  <= out_byte;
              end
            end
            2'd1: begin
              q      <= 2'd2;
              scl_oe <= 1'b0;
            end
            2'd2: if (scl_in) begin
              q <= 2'd3;
              if (bitn == 4'd8) ack_bit <= sda_in;
              else              shift   <= {shift[6:0], sda_in};
            end
            default: begin
              q      <= 2'd0;
              scl_oe <= 1'b1;
              if (bitn != 4'd8) begin
                bitn <= bitn + 1'b1;
              end else begin
                bitn <= '0;
                if (sends && ack_bit) begin
                  err   <= 1'b1;
                  state <= ST_HOLD;
                end else if (is_addr) begin
                  is_addr <= 1'b0;
                end else begin
                  if (rw_q) begin
                    rx_we   <= 1'b1;
                    rx_idx  <= idx;
                    rx_byte <= shift;
                  end
                  if (idx == last_q) begin
                    done  <= 1'b1;
                    state <= ST_HOLD;
                  end else begin
                    idx <= idx + 1'b1;
                  end
                end
              end
            end
          endcase
        end
        ST_STOP: if (tick) begin
          q <= q + 1'b1;
          case (q)
            2'd0: sda_oe <= 1'b1;
            2'd1: scl_oe <= 1'b0;
            2'd2: sda_oe <= 1'b0;
            default: state <= ST_IDLE;
          endcase
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/i2c_burst_master.sv
module i2c_burst_master
  import i2cb_pkg::*;
#(
  parameter int ADDR_W  = 5,
  parameter int DEPTH   = 16,
  parameter int QTR_DIV = 250
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_we,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  input  logic              scl_in,
  input  logic              sda_in,
  output logic              scl_oe,
  output logic              sda_oe
);
  localparam int IDX_W = $clog2(DEPTH);
  localparam logic [ADDR_W-1:0] A_CNT  = ADDR_W'(OFS_COUNT);
  localparam logic [ADDR_W-1:0] A_CTL  = ADDR_W'(OFS_CTRL);
  localparam logic [ADDR_W-1:0] A_STS  = ADDR_W'(OFS_STAT);
  localparam logic [ADDR_W-1:0] A_SAD  = ADDR_W'(OFS_SADDR);
  localparam logic [ADDR_W-1:0] A_CLR  = ADDR_W'(OFS_CLR);
  localparam logic [ADDR_W-1:0] A_DATA = ADDR_W'(OFS_DATA);

  logic [IDX_W-1:0] cnt_q;
  logic [7:0]       status_q, saddr_q;
  logic [7:0]       buf_q [DEPTH];
  logic [1:0]       scl_sync, sda_sync;

  logic [ADDR_W-1:0] dofs;
  logic              in_data;
  logic [IDX_W-1:0]  didx;
  logic              start_cmd, stop_cmd;

  logic             tick, eng_done, eng_err, eng_rx_we, eng_ready;
  logic [IDX_W-1:0] eng_idx, eng_rx_idx;
  logic [7:0]       eng_rx_byte;
  eng_st_e          eng_state;

  assign dofs      = reg_addr - A_DATA;
  assign in_data   = (reg_addr >= A_DATA) && (dofs < ADDR_W'(DEPTH));
  assign didx      = dofs[IDX_W-1:0];
  assign start_cmd = reg_we && reg_addr == A_CTL && reg_wdata[CTL_EN] && reg_wdata[CTL_GO] && eng_ready;
  assign stop_cmd  = reg_we && reg_addr == A_CTL && reg_wdata[CTL_EN] && !reg_wdata[CTL_GO];

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_sync <= 2'b11;
      sda_sync <= 2'b11;
    end else begin
      scl_sync <= {scl_sync[0], scl_in};
      sda_sync <= {sda_sync[0], sda_in};
    end
  end

  i2cb_tick #(.DIV(QTR_DIV)) u_tick (.clk(clk), .rst(rst), .tick(tick));

  i2cb_engine #(.IDX_W(IDX_W)) u_eng (
    .clk(clk), .rst(rst), .tick(tick),
    .go(start_cmd), .halt(stop_cmd),
    .addr_byte(saddr_q), .last_idx(cnt_q), .tx_byte(buf_q[eng_idx]),
    .scl_in(scl_sync[1]), .sda_in(sda_sync[1]),
    .scl_oe(scl_oe), .sda_oe(sda_oe),
    .idx(eng_idx), .rx_we(eng_rx_we), .rx_idx(eng_rx_idx), .rx_byte(eng_rx_byte),
    .done(eng_done), .err(eng_err), .ready(eng_ready), .state(eng_state)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= '0;
      saddr_q <= '0;
    end else if (reg_we) begin
      if (reg_addr == A_CNT) cnt_q   <= reg_wdata[IDX_W-1:0];
      if (reg_addr == A_SAD) saddr_q <= reg_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      status_q <= '0;
    end else if (eng_done) begin
      status_q <= STS_DONE;
    end else if (eng_err) begin
      status_q[STS_ERR] <= 1'b1;
      status_q[STS_BSY] <= 1'b0;
    end else begin
      if (start_cmd) status_q[STS_BSY] <= 1'b1;
      if (stop_cmd || (reg_we && reg_addr == A_CLR)) status_q[STS_ERR] <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) buf_q[i] <= '0;
    end else if (eng_rx_we) begin
      buf_q[eng_rx_idx] <= eng_rx_byte;
    end else if (reg_we && in_data) begin
      buf_q[didx] <= reg_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
    end else if (in_data) begin
      reg_rdata <= buf_q[didx];
    end else begin
      case (reg_addr)
        A_CNT:   reg_rdata <= 8'(cnt_q);
        A_STS:   reg_rdata <= status_q;
        A_SAD:   reg_rdata <= saddr_q;
        default: reg_rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/i2cb_checker.sv
module i2cb_checker
  import i2cb_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int IDX_W  = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              reg_we,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [7:0]        reg_wdata,
  input logic [IDX_W-1:0]  cnt_q,
  input logic [7:0]        status_q,
  input logic              scl_oe,
  input logic              sda_oe,
  input eng_st_e           eng_state,
  input logic              eng_done,
  input logic              eng_err
);
  p_count_mask_r1: assert property (@(posedge clk) disable iff (rst)
    (reg_we && reg_addr == ADDR_W'(OFS_COUNT)) |=> (cnt_q == $past(reg_wdata[IDX_W-1:0])));

  p_busy_during_byte_r4: assert property (@(posedge clk) disable iff (rst)
    (eng_state == ST_BYTE) |-> status_q[STS_BSY]);

  p_idle_released_r5: assert property (@(posedge clk) disable iff (rst)
    (eng_state == ST_IDLE) |-> (!scl_oe && !sda_oe));

  p_nack_flags_r6: assert property (@(posedge clk) disable iff (rst)
    eng_err |=> (status_q[STS_ERR] && !status_q[STS_BSY]));

  p_done_code_r7: assert property (@(posedge clk) disable iff (rst)
    eng_done |=> (status_q == STS_DONE));

  p_sda_moves_low_r13: assert property (@(posedge clk) disable iff (rst)
    (!$past(scl_oe) && (sda_oe != $past(sda_oe))) |->
      ($past(eng_state) == ST_START || $past(eng_state) == ST_STOP));
endmodule

bind i2c_burst_master i2cb_checker #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
  .cnt_q(cnt_q), .status_q(status_q), .scl_oe(scl_oe), .sda_oe(sda_oe),
  .eng_state(eng_state), .eng_done(eng_done), .eng_err(eng_err)
);

// File: tb/test_i2c_burst_master.sv
module test_i2c_burst_master;
  localparam int CLK_PERIOD = 10;
  localparam logic [6:0] SLV = 7'h50;

  logic clk = 1'b0, rst = 1'b1;
  logic [4:0] reg_addr = '0;
  logic reg_we = 1'b0;
  logic [7:0] reg_wdata = '0, reg_rdata;
  logic scl_oe, sda_oe;
  logic s_oe = 1'b0;
  wire  scl_line = ~scl_oe;
  wire  sda_line = ~(sda_oe | s_oe);
  int   n_checks = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  i2c_burst_master #(.ADDR_W(5), .DEPTH(16), .QTR_DIV(4)) i_i2c_burst_master (
    .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_we(reg_we), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .scl_in(scl_line), .sda_in(sda_line),
    .scl_oe(scl_oe), .sda_oe(sda_oe));

  // behavioural slave
  logic [7:0] s_mem [256];
  logic [7:0] s_sh = '0, s_tx = '0, s_ptr = '0;
  logic s_active = 0, s_addrph = 0, s_rd = 0, s_mack = 1, s_ptr_set = 0;
  int s_cnt = 0, s_wcount = 0, s_nack_at = -1, s_rbytes = 0;

  function automatic logic [7:0] init_val(int i);
    return 8'((i * 7 + 3) & 255);
  endfunction

  initial for (int i = 0; i < 256; i++) s_mem[i] = init_val(i);

  always @(negedge sda_line) if (scl_line === 1'b1) begin
    s_active = 1; s_addrph = 1; s_cnt = 0; s_rd = 0; s_oe = 0; s_ptr_set = 0; s_wcount = 0;
  end
  always @(posedge sda_line) if (scl_line === 1'b1) begin
    s_active = 0; s_oe = 0;
  end
  always @(posedge scl_line) if (s_active) begin
    if (s_cnt < 8) s_sh = {s_sh[6:0], sda_line};
    else if (s_cnt == 8) s_mack = sda_line;
    s_cnt++;
  end
  always @(negedge scl_line) if (s_active) begin
    if (s_cnt == 8) begin
      if (s_addrph) begin
        if (s_sh[7:1] == SLV) begin s_oe = 1; s_rd = s_sh[0]; end
        else begin s_oe = 0; s_active = 0; end
      end else if (!s_rd) begin
        if (!s_ptr_set) begin s_ptr = s_sh; s_ptr_set = 1; end
        else begin s_mem[s_ptr] = s_sh; s_ptr++; end
        s_oe = (s_wcount != s_nack_at);
        s_wcount++;
      end else s_oe = 0;
    end else if (s_cnt == 9) begin
      s_cnt = 0;
      if (s_rd && (s_addrph || !s_mack)) begin
        s_tx = s_mem[s_ptr]; s_ptr++; s_rbytes++; s_oe = !s_tx[7];
      end else s_oe = 0;
      s_addrph = 0;
    end else if (s_rd && !s_addrph && s_cnt >= 1 && s_cnt <= 7) begin
      s_oe = !s_tx[7 - s_cnt];
    end
  end

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic wr(logic [4:0] a, logic [7:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic rd(logic [4:0] a, output logic [7:0] d);
    @(negedge clk); reg_addr = a; reg_we = 1'b0;
    @(negedge clk); d = reg_rdata;
  endtask

  task automatic wait_idle(string req);
    logic [7:0] s;
    int n = 0;
    do begin rd(5'h02, s); n++; end while (s[0] && n < 20000);
    if (n >= 20000) check(req, s, 8'h00);
  endtask

  task automatic check_released(string req);
    repeat (40) @(negedge clk);
    check(req, {6'b0, scl_oe, sda_oe}, 8'h00);
  endtask

  task automatic t_reset;
    logic [7:0] v;
    rd(5'h00, v); check("R10 count after reset", v, 8'h00);
    rd(5'h02, v); check("R10 status after reset", v, 8'h00);
    rd(5'h03, v); check("R10 saddr after reset", v, 8'h00);
    rd(5'h0C, v); check("R10 buffer after reset", v, 8'h00);
  endtask

  task automatic t_regs;
    logic [7:0] v;
    wr(5'h00, 8'hF3); rd(5'h00, v); check("R1 count masked", v, 8'h03);
    wr(5'h18, 8'h77); rd(5'h18, v); check("R11 unmapped reads zero", v, 8'h00);
    rd(5'h05, v); check("R11 unmapped write ignored", v, 8'h00);
    wr(5'h04, 8'hFF); rd(5'h04, v); check("R11 reset offset reads zero", v, 8'h00);
    wr(5'h01, 8'h04);
    rd(5'h02, v); check("R3 no enable keeps status", v, 8'h00);
    check_released("R3 no enable keeps bus idle");
  endtask

  task automatic t_write_burst;
    logic [7:0] v;
    wr(5'h03, 8'hA0); rd(5'h03, v); check("R2 saddr readback", v, 8'hA0);
    wr(5'h05, 8'h10); wr(5'h06, 8'h5A); wr(5'h07, 8'hC3);
    rd(5'h06, v); check("R10 buffer readback", v, 8'h5A);
    wr(5'h00, 8'h02);
    wr(5'h01, 8'h05);
    rd(5'h02, v); check("R4 busy after start", v, 8'h01);
    wait_idle("R4 write burst timeout");
    rd(5'h02, v); check("R7 write burst done code", v, 8'h08);
    check("R9 first data byte", s_mem[8'h10], 8'h5A);
    check("R9 second data byte", s_mem[8'h11], 8'hC3);
    wr(5'h01, 8'h01);
    check_released("R5 stop releases bus");
    rd(5'h02, v); check("R5 stop keeps done code", v, 8'h08);
  endtask

  task automatic t_read_burst;
    logic [7:0] v;
    int rb0;
    wr(5'h03, 8'hA0); wr(5'h05, 8'h20); wr(5'h00, 8'h00);
    wr(5'h01, 8'h05); wait_idle("R4 offset write timeout");
    wr(5'h03, 8'hA1); wr(5'h00, 8'h03);
    rb0 = s_rbytes;
    wr(5'h01, 8'h05); wait_idle("R4 read burst timeout");
    rd(5'h02, v); check("R7 read burst done code", v, 8'h08);
    for (int i = 0; i < 4; i++) begin
      rd(5'(5 + i), v); check("R9 read byte order", v, init_val(8'h20 + i));
    end
    rd(5'h09, v); check("R1 byte past count untouched", v, 8'h00);
    check("R12 last byte not acknowledged", 8'(s_rbytes - rb0), 8'd4);
    wr(5'h01, 8'h01); check_released("R5 stop after read");
  endtask

  task automatic t_full_read;
    logic [7:0] v;
    wr(5'h03, 8'hA0); wr(5'h05, 8'h40); wr(5'h00, 8'h00);
    wr(5'h01, 8'h05); wait_idle("R4 offset write timeout");
    wr(5'h03, 8'hA1); wr(5'h00, 8'h0F);
    wr(5'h01, 8'h05); wait_idle("R1 full read timeout");
    rd(5'h05, v); check("R1 full read first", v, init_val(8'h40));
    rd(5'h14, v); check("R1 full read sixteenth", v, init_val(8'h4F));
    wr(5'h01, 8'h01); check_released("R5 stop after full read");
  endtask

  task automatic t_addr_nack;
    logic [7:0] v, keep;
    rd(5'h05, keep);
    wr(5'h03, 8'hA3); wr(5'h00, 8'h02);
    wr(5'h01, 8'h05); wait_idle("R6 addr nack timeout");
    rd(5'h02, v); check("R6 addr nack flags", v, 8'h0C);
    rd(5'h05, v); check("R6 buffer untouched on nack", v, keep);
    wr(5'h04, 8'h5A);
    rd(5'h02, v); check("R8 reset reg clears error only", v, 8'h08);
    wr(5'h01, 8'h01); check_released("R5 stop after addr nack");
  endtask

  task automatic t_data_nack;
    logic [7:0] v;
    s_nack_at = 1;
    wr(5'h03, 8'hA0);
    wr(5'h05, 8'h30); wr(5'h06, 8'h11); wr(5'h07, 8'h22); wr(5'h08, 8'h33);
    wr(5'h00, 8'h03);
    wr(5'h01, 8'h05); wait_idle("R6 data nack timeout");
    rd(5'h02, v); check("R6 data nack flags", v, 8'h0C);
    check("R6 refused byte still latched", s_mem[8'h30], 8'h11);
    check("R6 remaining bytes skipped", s_mem[8'h31], init_val(8'h31));
    wr(5'h01, 8'h01);
    rd(5'h02, v); check("R5 stop clears error", v, 8'h08);
    check_released("R5 stop after data nack");
    s_nack_at = -1;
  endtask

  logic finished = 1'b0;

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    t_reset();
    t_regs();
    t_write_burst();
    t_read_burst();
    t_full_read();
    t_addr_nack();
    t_data_nack();
    finished = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end
endmodule